// File: doc/BRIEF.md
# 16-bit Host to 32-bit Register Bridge

This block lets a host with a 16-bit data bus reach a 32-bit internal register or FIFO port. Two host writes to the two halves of one 32-bit word are gathered into a single internal write. An internal read is split into two host reads. The host may take the two halves in either order. An access that repeats the half already taken is not accepted as the second half. A change of word address, or of access kind, in the middle of a transfer abandons the pending half.

Host strobes are single-cycle pulses that are synchronous to `clk`. Host address bit 1 selects the half. Bits 2 and up give the word address, and bit 0 is unused.

A 32-bit swap control value exchanges the two halves. The swap applies only when every bit of that value is set. The internal read data is combinational: it is valid in the same cycle as the read strobe. Each internal read is captured into a snapshot, so the second host half comes from the same word as the first.

Top module: `halfword_bridge`

## Requirements
- R1: A host write to one half, then a host write to the other half of the same word, issues exactly one internal write in the cycle after the second write. That write carries the word address and the assembled 32-bit data, and the first half may be either one.
- R2: A second host write to the same half and word as a pending write is dropped: no internal write is issued and nothing is pending afterwards. The next write starts a new transfer.
- R3: A host read that is not the second half of a pending read does the following:
  - It raises the internal read strobe in the same cycle, with the word address.
  - It latches the full 32-bit word.
  - It presents the selected half on the host read data one cycle later.
- R4: A host read of the opposite half of a pending read, in the same word, returns that half from the snapshot one cycle later. It issues no internal read and ignores any change to the register since the first half.
- R5: A host read of the same half and word as a pending read returns 0000h one cycle later and clears the sequence. The next read launches a new internal read.
- R6: The half select is address bit 1 XOR swap, where swap is 1 only when the swap control equals FFFFFFFFh. The selected half maps to the word as follows:
  - Half 0 maps to bits 15:0. Host data bits 7:0 carry byte 0 and bits 15:8 carry byte 1.
  - Half 1 maps to bits 31:16, carrying bytes 2 and 3.
- R7: An access whose word address differs from the pending one abandons the pending half and is treated as a first half.
- R8: A read between two writes abandons the pending write, and a write between two reads abandons the pending read. When read and write strobes are raised together, the write is taken and the read is ignored: there is no internal read.
- R9: After reset, the internal write strobe is low, nothing is pending and the host read data is 0000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hostAddr | input | AW | Host byte address; bit 1 selects the half, bits AW-1:2 select the word |
| hostWr | input | 1 | Host write strobe, one cycle |
| hostRd | input | 1 | Host read strobe, one cycle |
| hostWdata | input | 16 | Host write data |
| hostRdata | output | 16 | Host read data, registered |
| swapCtl | input | 32 | Half-swap control; swap only when all ones |
| regWr | output | 1 | Internal write strobe |
| regWrAddr | output | AW-2 | Internal write word address |
| regWdata | output | 32 | Internal write data |
| regRd | output | 1 | Internal read strobe |
| regRdAddr | output | AW-2 | Internal read word address |
| regRdata | input | 32 | Internal read data, valid with regRd |

## Verification
The results of this block fall due at different points:
- An internal read strobe and its address fall due in the same cycle as the host read, so the bench samples them shortly after driving inputs on the falling edge.
- An internal write falls due one clock after the completing host write, so the bench samples it on the next falling edge.
- Host read data also falls due one clock after the read, and is sampled on the next falling edge.

Expected values come from a behavioural sequence model in the bench. The model tracks the pending kind, half and word, and a snapshot taken from the bench-held register array. The bench alters that array between read halves to show that the snapshot is kept.

// File: rtl/hbr_pkg.sv
package hbr_pkg;
  typedef enum logic [1:0] {SEQ_IDLE, SEQ_WR, SEQ_RD} seq_e;

  typedef struct packed {
    logic effHalf;   // half after swap
    logic wrFirst;   // store first write half
    logic wrFire;    // assemble and issue internal write
    logic rdLaunch;  // launch internal read, take snapshot
    logic rdSecond;  // serve other half from snapshot
    logic rdBad;     // repeated half: invalid data
  } hbrStrobe_t;
endpackage

// File: rtl/hbr_ctrl.sv
module hbr_ctrl
  import hbr_pkg::*;
#(
  parameter int WA = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hostWr,
  input  logic          hostRd,
  input  logic          hostA1,
  input  logic [WA-1:0] hostWord,
  input  logic          swapOn,
  output hbrStrobe_t    st
);
  seq_e          kind;
  logic          pendHalf;
  logic [WA-1:0] pendWord;
  logic          rdEn, sameWord, rdMatch, wrMatch;

  always_comb begin
    rdEn        = hostRd & ~hostWr;
    sameWord    = (hostWord == pendWord);
    wrMatch     = hostWr && (kind == SEQ_WR) && sameWord;
    rdMatch     = rdEn && (kind == SEQ_RD) && sameWord;
    st.effHalf  = hostA1 ^ swapOn;
    st.wrFirst  = hostWr && !wrMatch;
    st.wrFire   = wrMatch && (st.effHalf != pendHalf);
    st.rdLaunch = rdEn && !rdMatch;
    st.rdSecond = rdMatch && (st.effHalf != pendHalf);
    st.rdBad    = rdMatch && (st.effHalf == pendHalf);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind     <= SEQ_IDLE;
      pendHalf <= 1'b0;
      pendWord <= '0;
    end else if (st.wrFirst || st.rdLaunch) begin
      kind     <= st.wrFirst ? SEQ_WR : SEQ_RD;
      pendHalf <= st.effHalf;
      pendWord <= hostWord;
    end else if (hostWr || rdEn) begin
      kind     <= SEQ_IDLE;
    end
  end
endmodule

// File: rtl/hbr_datapath.sv
module hbr_datapath
  import hbr_pkg::*;
#(
  parameter int WA = 6,
  parameter int HW = 16,
  localparam int DW = 2 * HW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  hbrStrobe_t    st,
  input  logic [WA-1:0] hostWord,
  input  logic [HW-1:0] hostWdata,
  input  logic [DW-1:0] regRdata,
  output logic          regWr,
  output logic [WA-1:0] regWrAddr,
  output logic [DW-1:0] regWdata,
  output logic [HW-1:0] hostRdata
);
  logic [HW-1:0] pendData;
  logic [DW-1:0] snap;
  logic [HW-1:0] liveHalf, snapHalf;

  always_comb begin
    liveHalf = st.effHalf ? regRdata[DW-1:HW] : regRdata[HW-1:0];
    snapHalf = st.effHalf ? snap[DW-1:HW]     : snap[HW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regWr     <= 1'b0;
      regWrAddr <= '0;
      regWdata  <= '0;
      pendData  <= '0;
      snap      <= '0;
      hostRdata <= '0;
    end else begin
      regWr <= st.wrFire;
      if (st.wrFirst) pendData <= hostWdata;
      if (st.wrFire) begin
        regWrAddr <= hostWord;
        regWdata  <= st.effHalf ? {hostWdata, pendData} : {pendData, hostWdata};
      end
      if (st.rdLaunch) begin
        snap      <= regRdata;
        hostRdata <= liveHalf;
      end else if (st.rdSecond) begin
        hostRdata <= snapHalf;
      end else if (st.rdBad) begin
        hostRdata <= '0;
      end
    end
  end
endmodule

// File: rtl/halfword_bridge.sv
module halfword_bridge
  import hbr_pkg::*;
#(
  parameter int AW = 8,
  parameter int HW = 16,
  localparam int WA = AW - 2,
  localparam int DW = 2 * HW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] hostAddr,
  input  logic          hostWr,
  input  logic          hostRd,
  input  logic [HW-1:0] hostWdata,
  output logic [HW-1:0] hostRdata,
  input  logic [31:0]   swapCtl,
  output logic          regWr,
  output logic [WA-1:0] regWrAddr,
  output logic [DW-1:0] regWdata,
  output logic          regRd,
  output logic [WA-1:0] regRdAddr,
  input  logic [DW-1:0] regRdata
);
  hbrStrobe_t    st;
  logic [WA-1:0] hostWord;
  logic          swapOn;

  assign hostWord  = hostAddr[AW-1:2];
  assign swapOn    = &swapCtl;
  assign regRd     = st.rdLaunch;
  assign regRdAddr = hostWord;

  hbr_ctrl #(.WA(WA)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .hostWr(hostWr), .hostRd(hostRd),
    .hostA1(hostAddr[1]), .hostWord(hostWord), .swapOn(swapOn), .st(st)
  );

  hbr_datapath #(.WA(WA), .HW(HW)) u_dp (
    .clk(clk), .rst_n(rst_n), .st(st), .hostWord(hostWord),
    .hostWdata(hostWdata), .regRdata(regRdata), .regWr(regWr),
    .regWrAddr(regWrAddr), .regWdata(regWdata), .hostRdata(hostRdata)
  );
endmodule

// File: rtl/hbr_chk.sv
module hbr_chk #(
  parameter int WA = 6,
  parameter int HW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hostWr,
  input logic          hostRd,
  input logic          regWr,
  input logic          regRd,
  input logic [WA-1:0] regWrAddr,
  input logic [HW-1:0] hostRdata
);
  // R1
  wr_after_host_chk: assert property (@(posedge clk) disable iff (!rst_n)
    regWr |-> $past(hostWr));
  // R1
  wraddr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !regWr |-> $stable(regWrAddr));
  // R2
  no_back_to_back_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    regWr |=> !regWr);
  // R3
  rd_needs_host_chk: assert property (@(posedge clk) disable iff (!rst_n)
    regRd |-> hostRd);
  // R8
  wr_blocks_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hostWr |-> !regRd);
  // R9
  reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!regWr && hostRdata == '0));
endmodule

bind halfword_bridge hbr_chk #(.WA(WA), .HW(HW)) u_chk (
  .clk(clk), .rst_n(rst_n), .hostWr(hostWr), .hostRd(hostRd),
  .regWr(regWr), .regRd(regRd), .regWrAddr(regWrAddr), .hostRdata(hostRdata)
);

// File: tb/halfword_bridge_tb.sv
module halfword_bridge_tb;
  localparam int AW = 8;
  localparam int WA = AW - 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] hostAddr = '0;
  logic          hostWr = 1'b0, hostRd = 1'b0;
  logic [15:0]   hostWdata = '0;
  logic [15:0]   hostRdata;
  logic [31:0]   swapCtl = 32'h0;
  logic          regWr, regRd;
  logic [WA-1:0] regWrAddr, regRdAddr;
  logic [31:0]   regWdata, regRdata;

  logic [31:0] mem [64];
  int checks = 0, fails = 0;

  // behavioural sequence model
  int          mKind = 0;  // 0 idle, 1 write pending, 2 read pending
  bit          mHalf;
  int          mWord;
  logic [15:0] mData;
  logic [31:0] mSnap;

  always #10 clk = ~clk;

  halfword_bridge #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .hostAddr(hostAddr), .hostWr(hostWr),
    .hostRd(hostRd), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .swapCtl(swapCtl), .regWr(regWr), .regWrAddr(regWrAddr),
    .regWdata(regWdata), .regRd(regRd), .regRdAddr(regRdAddr),
    .regRdata(regRdata)
  );

  assign regRdata = mem[regRdAddr];
  always @(posedge clk) if (regWr) mem[regWrAddr] <= regWdata;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] pick(input logic [31:0] w, input bit h);
    return h ? w[31:16] : w[15:0];
  endfunction

  task automatic access(input string tag, input bit isWr, input bit isRd,
                        input int word, input bit a1, input logic [15:0] d);
    bit          eff, expWr, expLaunch;
    logic [31:0] expData;
    logic [15:0] expRd;
    @(negedge clk);
    hostAddr  = {word[WA-1:0], a1, 1'b0};
    hostWr    = isWr;
    hostRd    = isRd;
    hostWdata = d;
    eff       = a1 ^ (swapCtl == 32'hFFFF_FFFF);
    expWr = 0; expLaunch = 0; expData = '0; expRd = '0;
    if (isWr) begin
      if (mKind == 1 && mWord == word) begin
        if (eff != mHalf) begin
          expWr   = 1;
          expData = eff ? {d, mData} : {mData, d};
        end
        mKind = 0;
      end else begin
        mKind = 1; mHalf = eff; mWord = word; mData = d;
      end
    end else if (isRd) begin
      if (mKind == 2 && mWord == word) begin
        expRd = (eff != mHalf) ? pick(mSnap, eff) : 16'h0000;
        mKind = 0;
      end else begin
        expLaunch = 1;
        mSnap = mem[word];
        expRd = pick(mSnap, eff);
        mKind = 2; mHalf = eff; mWord = word;
      end
    end
    #1;
    check({tag, " regRd"}, {31'b0, regRd}, {31'b0, expLaunch});
    if (expLaunch) check({tag, " regRdAddr"}, {26'b0, regRdAddr}, word);
    @(negedge clk);
    hostWr = 0; hostRd = 0;
    check({tag, " regWr"}, {31'b0, regWr}, {31'b0, expWr});
    if (expWr) begin
      check({tag, " regWrAddr"}, {26'b0, regWrAddr}, word);
      check({tag, " regWdata"}, regWdata, expData);
    end
    if (isRd && !isWr) check({tag, " hostRdata"}, {16'b0, hostRdata}, {16'b0, expRd});
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'hA500_0000 | (i * 32'h0001_0203);
    repeat (3) @(negedge clk);
    check("R9 regWr", {31'b0, regWr}, 32'd0);
    check("R9 hostRdata", {16'b0, hostRdata}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 regWr after release", {31'b0, regWr}, 32'd0);

    // R1: low then high, high then low
    access("R1 lo first", 1, 0, 3, 0, 16'h1111);
    access("R1 hi second", 1, 0, 3, 1, 16'h2222);
    access("R1 hi first", 1, 0, 4, 1, 16'h4444);
    access("R1 lo second", 1, 0, 4, 0, 16'h3333);

    // R2: same half twice dropped, then fresh transfer
    access("R2 first", 1, 0, 5, 0, 16'h5555);
    access("R2 repeat", 1, 0, 5, 0, 16'h6666);
    access("R2 fresh hi", 1, 0, 5, 1, 16'h7777);
    access("R2 fresh lo", 1, 0, 5, 0, 16'h8888);

    // R3, R4: read with snapshot kept across a register change
    access("R3 rd lo", 0, 1, 3, 0, 16'h0);
    mem[3] = 32'hDEAD_BEEF;
    access("R4 rd hi snapshot", 0, 1, 3, 1, 16'h0);
    access("R3 rd hi first", 0, 1, 4, 1, 16'h0);
    access("R4 rd lo second", 0, 1, 4, 0, 16'h0);

    // R5: repeated read half
    access("R5 rd lo", 0, 1, 9, 0, 16'h0);
    access("R5 rd lo again", 0, 1, 9, 0, 16'h0);
    access("R5 relaunch", 0, 1, 9, 1, 16'h0);

    // R6: swap only on all ones
    swapCtl = 32'hFFFF_FFFF;
    access("R6 swap a1=0", 1, 0, 10, 0, 16'hAAAA);
    access("R6 swap a1=1", 1, 0, 10, 1, 16'hBBBB);
    access("R6 swap rd", 0, 1, 11, 0, 16'h0);
    access("R6 swap rd2", 0, 1, 11, 1, 16'h0);
    swapCtl = 32'hFFFF_FFFE;
    access("R6 near-all-ones lo", 1, 0, 12, 0, 16'hCCCC);
    access("R6 near-all-ones hi", 1, 0, 12, 1, 16'hDDDD);
    access("R6 near-all-ones rd", 0, 1, 11, 0, 16'h0);
    swapCtl = 32'h0;

    // R7: word change abandons pending
    access("R7 lo word6", 1, 0, 6, 0, 16'h1234);
    access("R7 hi word7", 1, 0, 7, 1, 16'h5678);
    access("R7 lo word7", 1, 0, 7, 0, 16'h9ABC);
    access("R7 rd word6", 0, 1, 6, 0, 16'h0);
    access("R7 rd word7", 0, 1, 7, 1, 16'h0);

    // R8: kind change abandons pending; write wins over read
    access("R8 wr lo", 1, 0, 8, 0, 16'h0F0F);
    access("R8 rd between", 0, 1, 8, 0, 16'h0);
    access("R8 wr hi", 1, 0, 8, 1, 16'hF0F0);
    access("R8 wr lo again", 1, 0, 8, 0, 16'h1F1F);
    access("R8 rd+wr together", 1, 1, 13, 0, 16'h2222);
    access("R8 rd+wr other half", 1, 1, 13, 1, 16'h3333);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 20);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule